// File: doc/BRIEF.md
# USB Endpoint Event Interrupt Unit

This block sits beside the protocol engine of a full-speed USB device controller, one instance per endpoint. It takes single-cycle event pulses from the engine and strobes from the application. It checks each event against the endpoint's configured transfer kind and direction. Events that pass set sticky status flags. A status bit is cleared by writing 1 to it. A mask register picks which flags drive the single combined interrupt line.

Some flags need more than one input before they set. Transfer completion waits for both the system-bus side and the USB side to report done, in either order. A dropped isochronous OUT packet cancels any half-finished completion and raises nothing. Back-to-back SETUP packets on a control OUT endpoint are counted, and a flag is raised on the fourth. Application disable and application NAK requests are held pending until the endpoint is idle, and only then reported as effective.

Top module: `ep_evt_irq`

## Requirements
- R1: After reset, the status vector, the mask vector and the interrupt output are all zero.
- R2: The transfer-complete flag (bit 0) is set only after both a bus-side done pulse and a USB-side done pulse have arrived. They may arrive in either order or in the same cycle. One pulse alone sets nothing.
- R3: The setup-done flag (bit 1) is set by a setup-done pulse only when the endpoint is control (type code 0) and OUT (direction input 0).
- R4: On an IN endpoint (direction input 1), the transmit-empty flag (bit 2) is set while the FIFO level is at or below DEPTH/2 when half-select is 1, or while the level is exactly 0 when half-select is 0. It never sets on an OUT endpoint.
- R5: The IN-token-on-empty-FIFO flag (bit 4) is set by an IN token pulse with FIFO level 0, but only on bulk (code 2) or interrupt (code 3) IN endpoints.
- R6: The OUT-token-while-disabled flag (bit 5) is set by an OUT token pulse on an OUT endpoint whose enable input is 0.
- R7: On a control OUT endpoint, the fourth SETUP token in a row sets the back-to-back flag (bit 9). Any IN token, OUT token or handshake pulse restarts the count at zero. While the count is saturated, further SETUP tokens do not set the flag again.
- R8: The timeout flag (bit 10) is set by a timeout pulse only on a control IN endpoint.
- R9: The NAK-sent flag (bit 3) and the application-NAK-effective flag (bit 8) apply only to isochronous (code 1) IN endpoints. An application NAK request is held pending while the busy input is 1. It is reported in the first cycle the busy input is 0.
- R10: A babble pulse sets bit 6 on any endpoint. An application disable request is held pending until the busy input is 0, and then sets the disable-effective flag (bit 7).
- R11: An isochronous packet-drop pulse on an isochronous OUT endpoint sets no flag. It discards any pending half of a transfer completion.
- R12: Writing 1 to a clear bit clears that status bit on the next cycle. A set in the same cycle wins over the clear. Bits not written stay set.
- R13: A mask write loads the whole mask vector. The interrupt output is high exactly when some status bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_type | input | 2 | Transfer kind: 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| ep_dir_in | input | 1 | 1 for an IN endpoint, 0 for OUT |
| ep_enabled | input | 1 | Endpoint enabled by the application |
| ep_busy | input | 1 | Endpoint has a transaction in progress |
| txf_half_sel | input | 1 | 1 selects the half-empty threshold for the transmit-empty flag |
| txf_level | input | LVL_W | Current transmit FIFO fill level in words |
| setup_tok_p | input | 1 | SETUP token received |
| setup_done_p | input | 1 | Setup stage finished |
| in_tok_p | input | 1 | IN token received |
| out_tok_p | input | 1 | OUT token received |
| hs_p | input | 1 | Handshake exchanged |
| bus_done_p | input | 1 | Bus-side transfer done |
| usb_done_p | input | 1 | USB-side transfer done |
| iso_drop_p | input | 1 | Isochronous OUT packet dropped |
| nak_sent_p | input | 1 | NAK sent to host |
| babble_p | input | 1 | Babble detected |
| timeout_p | input | 1 | Response timeout detected |
| app_dis_req | input | 1 | Application requests endpoint disable |
| app_nak_req | input | 1 | Application requests NAK mode |
| clr_w1c | input | NUM_EV | Write-1-to-clear strobes for the status bits |
| mask_wr | input | 1 | Mask load strobe |
| mask_wdata | input | NUM_EV | Mask value to load |
| status | output | NUM_EV | Sticky status flags |
| mask | output | NUM_EV | Current mask |
| irq | output | 1 | Combined masked interrupt |

## Verification
Most internal state shows at the ports one cycle after the pulse that should change it. Suppose the completion trackers keep a stale half after a flag or a drop. The next lone done pulse then raises bit 0 at once, where it should raise nothing. A wrong SETUP run count makes bit 9 appear one token early or late, or a second time after a clear. A pending disable or NAK that is lost or never retired shows as a missing flag, or as a flag that sets again, in the cycle after busy falls.

// File: rtl/ep_evt_pkg.sv
package ep_evt_pkg;

    typedef enum logic [1:0] {
        EPT_CTRL = 2'd0,
        EPT_ISO  = 2'd1,
        EPT_BULK = 2'd2,
        EPT_INTR = 2'd3
    } ep_kind_e;

    localparam int EV_XFER     = 0;
    localparam int EV_SETUP    = 1;
    localparam int EV_TXE      = 2;
    localparam int EV_ISO_NAK  = 3;
    localparam int EV_IN_EMPTY = 4;
    localparam int EV_OUT_DIS  = 5;
    localparam int EV_BABBLE   = 6;
    localparam int EV_DIS_EFF  = 7;
    localparam int EV_NAK_EFF  = 8;
    localparam int EV_B2B      = 9;
    localparam int EV_TMO      = 10;
    localparam int EV_COUNT    = 11;

endpackage

// File: rtl/ep_evt_qual.sv
module ep_evt_qual
    import ep_evt_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  ep_kind_e             kind,
    input  logic                 dir_in,
    input  logic                 enabled,
    input  logic                 half_sel,
    input  logic [LVL_W-1:0]     level,
    input  logic                 setup_done_p,
    input  logic                 in_tok_p,
    input  logic                 out_tok_p,
    input  logic                 nak_sent_p,
    input  logic                 babble_p,
    input  logic                 timeout_p,
    input  logic                 xfer_fire,
    input  logic                 b2b_fire,
    input  logic                 dis_fire,
    input  logic                 nak_fire,
    output logic [EV_COUNT-1:0]  set_vec
);

    localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(DEPTH / 2);

    logic is_ctrl, is_iso, is_bulk, is_intr;
    logic lvl_zero, lvl_half, txe_cond;

    always_comb begin
        is_ctrl  = (kind == EPT_CTRL);
        is_iso   = (kind == EPT_ISO);
        is_bulk  = (kind == EPT_BULK);
        is_intr  = (kind == EPT_INTR);
        lvl_zero = (level == '0);
        lvl_half = (level <= HALF_LVL);
        txe_cond = half_sel ? lvl_half : lvl_zero;

        set_vec              = '0;
        set_vec[EV_XFER]     = xfer_fire;
        set_vec[EV_SETUP]    = setup_done_p & is_ctrl & ~dir_in;
        set_vec[EV_TXE]      = dir_in & txe_cond;
        set_vec[EV_ISO_NAK]  = nak_sent_p & is_iso & dir_in;
        set_vec[EV_IN_EMPTY] = in_tok_p & (is_bulk | is_intr) & dir_in & lvl_zero;
        set_vec[EV_OUT_DIS]  = out_tok_p & ~dir_in & ~enabled;
        set_vec[EV_BABBLE]   = babble_p;
        set_vec[EV_DIS_EFF]  = dis_fire;
        set_vec[EV_NAK_EFF]  = nak_fire & is_iso & dir_in;
        set_vec[EV_B2B]      = b2b_fire;
        set_vec[EV_TMO]      = timeout_p & is_ctrl & dir_in;
    end

endmodule

// File: rtl/ep_evt_track.sv
module ep_evt_track #(
    parameter int SETUP_LIMIT = 3,
    parameter int CNT_W       = $clog2(SETUP_LIMIT + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_ctrl_out,
    input  logic is_iso_out,
    input  logic bus_done_p,
    input  logic usb_done_p,
    input  logic iso_drop_p,
    input  logic setup_tok_p,
    input  logic in_tok_p,
    input  logic out_tok_p,
    input  logic hs_p,
    input  logic app_dis_req,
    input  logic app_nak_req,
    input  logic ep_busy,
    output logic xfer_fire,
    output logic b2b_fire,
    output logic dis_fire,
    output logic nak_fire
);

    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(SETUP_LIMIT);
    localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(SETUP_LIMIT + 1);

    typedef struct packed {
        logic             bus_seen;
        logic             usb_seen;
        logic [CNT_W-1:0] run_cnt;
        logic             dis_pend;
        logic             nak_pend;
    } trk_s;

    trk_s s_d, s_q;
    logic drop_now, bus_any, usb_any, run_break;

    always_comb begin
        s_d       = s_q;
        drop_now  = iso_drop_p & is_iso_out;
        bus_any   = bus_done_p | s_q.bus_seen;
        usb_any   = usb_done_p | s_q.usb_seen;
        run_break = in_tok_p | out_tok_p | hs_p;

        xfer_fire = bus_any & usb_any & ~drop_now;
        if (drop_now || xfer_fire) begin
            s_d.bus_seen = 1'b0;
            s_d.usb_seen = 1'b0;
        end else begin
            s_d.bus_seen = bus_any;
            s_d.usb_seen = usb_any;
        end

        b2b_fire = 1'b0;
        if (!is_ctrl_out || run_break) begin
            s_d.run_cnt = '0;
        end else if (setup_tok_p) begin
            b2b_fire = (s_q.run_cnt == CNT_LIMIT);
            if (s_q.run_cnt != CNT_SAT)
                s_d.run_cnt = s_q.run_cnt + 1'b1;
        end

        dis_fire = s_q.dis_pend & ~ep_busy;
        if (app_dis_req)
            s_d.dis_pend = 1'b1;
        else if (dis_fire)
            s_d.dis_pend = 1'b0;

        nak_fire = s_q.nak_pend & ~ep_busy;
        if (app_nak_req)
            s_d.nak_pend = 1'b1;
        else if (nak_fire)
            s_d.nak_pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assert_run_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run_cnt <= CNT_SAT);

    assert_run_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctrl_out && (in_tok_p || out_tok_p || hs_p)) |=> (s_q.run_cnt == '0));

    assert_xfer_retire_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_fire |=> (!s_q.bus_seen && !s_q.usb_seen));

    assert_drop_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_drop_p && is_iso_out) |=> (!s_q.bus_seen && !s_q.usb_seen));

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_busy && s_q.dis_pend) |=> s_q.dis_pend);

endmodule

// File: rtl/ep_evt_regs.sv
module ep_evt_regs #(
    parameter int NUM_EV = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] set_vec,
    input  logic [NUM_EV-1:0] clr_w1c,
    input  logic              mask_wr,
    input  logic [NUM_EV-1:0] mask_wdata,
    output logic [NUM_EV-1:0] status,
    output logic [NUM_EV-1:0] mask,
    output logic              irq
);

    typedef struct packed {
        logic [NUM_EV-1:0] stat;
        logic [NUM_EV-1:0] msk;
    } reg_s;

    reg_s r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.stat = (r_q.stat & ~clr_w1c) | set_vec;
        if (mask_wr)
            r_d.msk = mask_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign status = r_q.stat;
    assign mask   = r_q.msk;
    assign irq    = |(r_q.stat & r_q.msk);

    assert_mask_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.msk == '0) |-> !irq);

    assert_mask_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask == $past(mask_wdata)));

    for (genvar i = 0; i < NUM_EV; i++) begin : g_bit
        assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> status[i]);

        assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_w1c[i] && !set_vec[i]) |=> !status[i]);

        assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(status[i]) |-> $past(clr_w1c[i]));
    end

endmodule

// File: rtl/ep_evt_irq.sv
module ep_evt_irq
    import ep_evt_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int SETUP_LIMIT = 3,
    parameter int NUM_EV      = EV_COUNT,
    parameter int LVL_W       = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ep_type,
    input  logic              ep_dir_in,
    input  logic              ep_enabled,
    input  logic              ep_busy,
    input  logic              txf_half_sel,
    input  logic [LVL_W-1:0]  txf_level,
    input  logic              setup_tok_p,
    input  logic              setup_done_p,
    input  logic              in_tok_p,
    input  logic              out_tok_p,
    input  logic              hs_p,
    input  logic              bus_done_p,
    input  logic              usb_done_p,
    input  logic              iso_drop_p,
    input  logic              nak_sent_p,
    input  logic              babble_p,
    input  logic              timeout_p,
    input  logic              app_dis_req,
    input  logic              app_nak_req,
    input  logic [NUM_EV-1:0] clr_w1c,
    input  logic              mask_wr,
    input  logic [NUM_EV-1:0] mask_wdata,
    output logic [NUM_EV-1:0] status,
    output logic [NUM_EV-1:0] mask,
    output logic              irq
);

    ep_kind_e          kind;
    logic              is_ctrl_out, is_iso_out;
    logic              xfer_fire, b2b_fire, dis_fire, nak_fire;
    logic [EV_COUNT-1:0] set_vec;

    always_comb begin
        kind        = ep_kind_e'(ep_type);
        is_ctrl_out = (kind == EPT_CTRL) & ~ep_dir_in;
        is_iso_out  = (kind == EPT_ISO) & ~ep_dir_in;
    end

    ep_evt_track #(
        .SETUP_LIMIT (SETUP_LIMIT)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .is_ctrl_out (is_ctrl_out),
        .is_iso_out  (is_iso_out),
        .bus_done_p  (bus_done_p),
        .usb_done_p  (usb_done_p),
        .iso_drop_p  (iso_drop_p),
        .setup_tok_p (setup_tok_p),
        .in_tok_p    (in_tok_p),
        .out_tok_p   (out_tok_p),
        .hs_p        (hs_p),
        .app_dis_req (app_dis_req),
        .app_nak_req (app_nak_req),
        .ep_busy     (ep_busy),
        .xfer_fire   (xfer_fire),
        .b2b_fire    (b2b_fire),
        .dis_fire    (dis_fire),
        .nak_fire    (nak_fire)
    );

    ep_evt_qual #(
        .DEPTH (DEPTH),
        .LVL_W (LVL_W)
    ) u_qual (
        .kind         (kind),
        .dir_in       (ep_dir_in),
        .enabled      (ep_enabled),
        .half_sel     (txf_half_sel),
        .level        (txf_level),
        .setup_done_p (setup_done_p),
        .in_tok_p     (in_tok_p),
        .out_tok_p    (out_tok_p),
        .nak_sent_p   (nak_sent_p),
        .babble_p     (babble_p),
        .timeout_p    (timeout_p),
        .xfer_fire    (xfer_fire),
        .b2b_fire     (b2b_fire),
        .dis_fire     (dis_fire),
        .nak_fire     (nak_fire),
        .set_vec      (set_vec)
    );

    ep_evt_regs #(
        .NUM_EV (NUM_EV)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .clr_w1c    (clr_w1c),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .status     (status),
        .mask       (mask),
        .irq        (irq)
    );

    assert_tmo_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[EV_TMO]) |-> $past(ep_type == 2'd0 && ep_dir_in));

    assert_isonak_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[EV_ISO_NAK]) |-> $past(ep_type == 2'd1 && ep_dir_in));

    assert_setup_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[EV_SETUP]) |-> $past(ep_type == 2'd0 && !ep_dir_in));

endmodule

// File: tb/tb_ep_evt_irq.sv
module tb_ep_evt_irq;

    localparam int N     = 11;
    localparam int DEPTH = 8;
    localparam int LW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n;
    logic [1:0] ep_type;
    logic ep_dir_in, ep_enabled, ep_busy, txf_half_sel;
    logic [LW-1:0] txf_level;
    logic setup_tok_p, setup_done_p, in_tok_p, out_tok_p, hs_p;
    logic bus_done_p, usb_done_p, iso_drop_p, nak_sent_p, babble_p, timeout_p;
    logic app_dis_req, app_nak_req, mask_wr;
    logic [N-1:0] clr_w1c, mask_wdata;
    logic [N-1:0] status, mask;
    logic irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [N-1:0] exp_st, exp_mk;
    logic [2*N:0] exp_q[$];
    string        tag_q[$];

    always #5 clk = ~clk;

    ep_evt_irq #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .ep_type(ep_type), .ep_dir_in(ep_dir_in),
        .ep_enabled(ep_enabled), .ep_busy(ep_busy), .txf_half_sel(txf_half_sel),
        .txf_level(txf_level), .setup_tok_p(setup_tok_p), .setup_done_p(setup_done_p),
        .in_tok_p(in_tok_p), .out_tok_p(out_tok_p), .hs_p(hs_p),
        .bus_done_p(bus_done_p), .usb_done_p(usb_done_p), .iso_drop_p(iso_drop_p),
        .nak_sent_p(nak_sent_p), .babble_p(babble_p), .timeout_p(timeout_p),
        .app_dis_req(app_dis_req), .app_nak_req(app_nak_req), .clr_w1c(clr_w1c),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .status(status), .mask(mask),
        .irq(irq)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // driver side: push expected outputs, then let one edge pass
    task automatic expect_now(input string tag);
        exp_q.push_back({|(exp_st & exp_mk), exp_mk, exp_st});
        tag_q.push_back(tag);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        clr_w1c = '1;
        @(negedge clk);
        clr_w1c = '0;
        exp_st  = '0;
    endtask

    task automatic set_ep(input logic [1:0] t, input logic din);
        ep_type   = t;
        ep_dir_in = din;
    endtask

    // monitor: pops expected items after the edge and compares
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (exp_q.size() > 0) begin
                logic [2*N:0] e;
                logic [2*N:0] a;
                string        t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {irq, mask, status};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        ep_type = 2'd2; ep_dir_in = 1'b0; ep_enabled = 1'b1; ep_busy = 1'b0;
        txf_half_sel = 1'b0; txf_level = LW'(DEPTH);
        setup_tok_p = 0; setup_done_p = 0; in_tok_p = 0; out_tok_p = 0; hs_p = 0;
        bus_done_p = 0; usb_done_p = 0; iso_drop_p = 0; nak_sent_p = 0;
        babble_p = 0; timeout_p = 0; app_dis_req = 0; app_nak_req = 0;
        clr_w1c = '0; mask_wr = 0; mask_wdata = '0;
        exp_st = '0; exp_mk = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_now("R1 reset state");

        // R2: both sides required, either order or together
        set_ep(2'd2, 1'b1);
        bus_done_p = 1; @(negedge clk); bus_done_p = 0;
        expect_now("R2 bus side alone");
        usb_done_p = 1; @(negedge clk); usb_done_p = 0;
        exp_st[0] = 1'b1;
        expect_now("R2 both sides done");
        clear_all();
        usb_done_p = 1; bus_done_p = 1; @(negedge clk); usb_done_p = 0; bus_done_p = 0;
        exp_st[0] = 1'b1;
        expect_now("R2 same cycle");
        clear_all();

        // R11: iso OUT drop discards the pending half
        set_ep(2'd1, 1'b0);
        bus_done_p = 1; @(negedge clk); bus_done_p = 0;
        iso_drop_p = 1; @(negedge clk); iso_drop_p = 0;
        usb_done_p = 1; @(negedge clk); usb_done_p = 0;
        expect_now("R11 drop cancels completion");
        bus_done_p = 1; @(negedge clk); bus_done_p = 0;
        exp_st[0] = 1'b1;
        expect_now("R11 fresh pair after drop");
        clear_all();

        // R3
        set_ep(2'd0, 1'b0);
        setup_done_p = 1; @(negedge clk); setup_done_p = 0;
        exp_st[1] = 1'b1;
        expect_now("R3 control OUT setup done");
        clear_all();
        set_ep(2'd2, 1'b0);
        setup_done_p = 1; @(negedge clk); setup_done_p = 0;
        expect_now("R3 bulk OUT ignored");

        // R4
        set_ep(2'd2, 1'b1); txf_half_sel = 1;
        txf_level = LW'(DEPTH / 2); @(negedge clk); txf_level = LW'(DEPTH);
        exp_st[2] = 1'b1;
        expect_now("R4 half threshold hit");
        clear_all();
        txf_level = LW'(DEPTH / 2 + 1); @(negedge clk); txf_level = LW'(DEPTH);
        expect_now("R4 above half");
        txf_half_sel = 0;
        txf_level = LW'(DEPTH / 2); @(negedge clk); txf_level = LW'(DEPTH);
        expect_now("R4 full-empty mode not empty");
        txf_level = '0; @(negedge clk); txf_level = LW'(DEPTH);
        exp_st[2] = 1'b1;
        expect_now("R4 completely empty");
        clear_all();
        set_ep(2'd2, 1'b0);
        txf_level = '0; @(negedge clk); txf_level = LW'(DEPTH);
        expect_now("R4 OUT endpoint ignored");

        // R5
        set_ep(2'd3, 1'b1);
        txf_level = '0; in_tok_p = 1; @(negedge clk); in_tok_p = 0; txf_level = LW'(DEPTH);
        exp_st[2] = 1'b1; exp_st[4] = 1'b1;
        expect_now("R5 interrupt IN empty token");
        clear_all();
        set_ep(2'd0, 1'b1);
        txf_level = '0; in_tok_p = 1; @(negedge clk); in_tok_p = 0; txf_level = LW'(DEPTH);
        exp_st[2] = 1'b1;
        expect_now("R5 control IN not qualified");
        clear_all();

        // R6
        set_ep(2'd2, 1'b0); ep_enabled = 0;
        out_tok_p = 1; @(negedge clk); out_tok_p = 0;
        exp_st[5] = 1'b1;
        expect_now("R6 OUT token disabled");
        clear_all();
        ep_enabled = 1;
        out_tok_p = 1; @(negedge clk); out_tok_p = 0;
        expect_now("R6 OUT token enabled");

        // R7
        set_ep(2'd0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            setup_tok_p = 1; @(negedge clk); setup_tok_p = 0;
        end
        hs_p = 1; @(negedge clk); hs_p = 0;
        for (int k = 0; k < 3; k++) begin
            setup_tok_p = 1; @(negedge clk); setup_tok_p = 0;
        end
        expect_now("R7 run broken by handshake");
        setup_tok_p = 1; @(negedge clk); setup_tok_p = 0;
        exp_st[9] = 1'b1;
        expect_now("R7 fourth setup in a row");
        clear_all();
        setup_tok_p = 1; @(negedge clk); setup_tok_p = 0;
        expect_now("R7 saturated no repeat");

        // R8
        set_ep(2'd0, 1'b1);
        timeout_p = 1; @(negedge clk); timeout_p = 0;
        exp_st[10] = 1'b1;
        expect_now("R8 control IN timeout");
        clear_all();
        set_ep(2'd2, 1'b1);
        timeout_p = 1; @(negedge clk); timeout_p = 0;
        expect_now("R8 bulk IN ignored");

        // R9
        set_ep(2'd1, 1'b1);
        nak_sent_p = 1; @(negedge clk); nak_sent_p = 0;
        exp_st[3] = 1'b1;
        expect_now("R9 iso IN nak sent");
        clear_all();
        set_ep(2'd2, 1'b1);
        nak_sent_p = 1; @(negedge clk); nak_sent_p = 0;
        expect_now("R9 bulk IN nak ignored");
        set_ep(2'd1, 1'b1); ep_busy = 1;
        app_nak_req = 1; @(negedge clk); app_nak_req = 0;
        @(negedge clk);
        expect_now("R9 nak pending while busy");
        ep_busy = 0;
        exp_st[8] = 1'b1;
        expect_now("R9 nak effective when idle");
        clear_all();

        // R10
        babble_p = 1; @(negedge clk); babble_p = 0;
        exp_st[6] = 1'b1;
        expect_now("R10 babble");
        clear_all();
        app_dis_req = 1; @(negedge clk); app_dis_req = 0;
        exp_st[7] = 1'b1;
        expect_now("R10 disable effective");
        clear_all();

        // R12
        babble_p = 1; timeout_p = 1; set_ep(2'd0, 1'b1);
        @(negedge clk); babble_p = 0; timeout_p = 0;
        babble_p = 1; clr_w1c = N'(1) << 6; @(negedge clk); babble_p = 0; clr_w1c = '0;
        exp_st[6] = 1'b1; exp_st[10] = 1'b1;
        expect_now("R12 set wins over clear");
        clr_w1c = N'(1) << 6; @(negedge clk); clr_w1c = '0;
        exp_st[6] = 1'b0;
        expect_now("R12 clear one bit only");

        // R13
        mask_wr = 1; mask_wdata = N'(1) << 6; @(negedge clk); mask_wr = 0;
        exp_mk = N'(1) << 6;
        expect_now("R13 masked bit clear irq low");
        mask_wr = 1; mask_wdata = N'(1) << 10; @(negedge clk); mask_wr = 0;
        exp_mk = N'(1) << 10;
        expect_now("R13 irq high on masked flag");
        clear_all();
        expect_now("R13 irq drops after clear");

        repeat (2) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule